// File: doc/BRIEF.md
# System Exception Priority Resolver

This block decides which system exception should be taken next. It watches the pending state of the non-maskable interrupt and three fixed system handlers: the supervisor call (exception 11), the deferred context-switch request (exception 14) and the system tick (exception 15). It can also watch one external interrupt request, which arrives already arbitrated by a wider interrupt controller and carries its own exception number and priority. Each system handler has a 2-bit programmable priority, where a smaller value means a more urgent handler. The non-maskable interrupt sits above every programmable level.

Every cycle the block qualifies each request with its enable input and picks the most urgent one. It then compares the winner with the exception that is running now and registers three results: the number of the pending winner (0 when no request qualifies), a flag telling whether a qualified external interrupt is pending, and a preempt request. The priority-mask special register is not applied here. Stacking and vector fetch belong to other blocks.

Top module: `sysexc_resolver`

## Requirements
- R1: While rst_n is low, pend_vec, ext_pending and preempt_req are all 0.
- R2: A programmable priority value of 0 is the most urgent and 3 the least urgent. The supervisor call uses svc_prio, the context-switch request uses psv_prio, the tick uses tick_prio and the external request uses ext_prio.
- R3: When nmi_pend is 1, pend_vec becomes 2, whatever the other requests and priorities are.
- R4: Without a non-maskable request, pend_vec becomes the number of the qualified request with the smallest priority value. The numbers are 11 for the supervisor call, 14 for the context-switch request, 15 for the tick and ext_num for the external request.
- R5: When two or more qualified requests share the smallest priority value, the one with the lower exception number wins.
- R6: A system request counts only when both its pending bit and its enable bit are 1, and the external request counts only when ext_pend and ext_en are both 1. A request that is pending but disabled never becomes pend_vec. When nothing qualifies, pend_vec is 0.
- R7: ext_pending equals ext_pend AND ext_en from the cycle before, whether or not the external request wins.
- R8: preempt_req is 1 only when a winner exists and its urgency is strictly higher than that of the running exception. Thread mode (active_num 0) is less urgent than every priority, so any winner preempts it. Equal urgency does not preempt.
- R9: The running exception's urgency comes from active_num. For 2 it is the non-maskable level, which nothing preempts. For 11, 14 and 15 it is the matching programmed priority. For 16 and above it is act_ext_prio. Any other nonzero number is treated as the non-maskable level.
- R10: All outputs are registered. A change on any input shows on the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| svc_pend | input | 1 | Supervisor call pending |
| svc_en | input | 1 | Supervisor call enable qualifier |
| svc_prio | input | 2 | Supervisor call priority |
| psv_pend | input | 1 | Context-switch request pending |
| psv_en | input | 1 | Context-switch request enable qualifier |
| psv_prio | input | 2 | Context-switch request priority |
| tick_pend | input | 1 | System tick pending |
| tick_en | input | 1 | System tick enable qualifier |
| tick_prio | input | 2 | System tick priority |
| ext_pend | input | 1 | External interrupt pending |
| ext_en | input | 1 | External interrupt enable/mask qualifier |
| ext_num | input | 9 | Exception number of the external request (16 or above) |
| ext_prio | input | 2 | Priority of the external request |
| active_num | input | 9 | Number of the running exception, 0 for thread mode |
| act_ext_prio | input | 2 | Priority of the running exception when it is external |
| pend_vec | output | 9 | Number of the winning pending exception, 0 when none |
| ext_pending | output | 1 | Qualified external interrupt pending |
| preempt_req | output | 1 | Winner should preempt the running exception |

## Verification
The assertions assume that ext_num is 16 or above whenever the external request is offered. Smaller numbers would collide with the fixed system numbers, and the tie rule would then order candidates by list position and not by number. The assertions also assume that inputs change only between clock edges. The bench drives every input on the falling edge. Every external number it draws, in the directed tasks and in the random sweep, is at least 16. The random sweep picks active numbers from thread mode, the fixed system numbers, an unassigned low number and the external range, so that every branch of the running-urgency mapping is exercised.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
  localparam int VEC_W  = 9;
  localparam int PRIO_W = 2;
  localparam int RANK_W = PRIO_W + 1;

  localparam logic [VEC_W-1:0] NUM_THREAD = VEC_W'(0);
  localparam logic [VEC_W-1:0] NUM_NMI    = VEC_W'(2);
  localparam logic [VEC_W-1:0] NUM_SVC    = VEC_W'(11);
  localparam logic [VEC_W-1:0] NUM_PSV    = VEC_W'(14);
  localparam logic [VEC_W-1:0] NUM_TICK   = VEC_W'(15);
  localparam logic [VEC_W-1:0] NUM_EXT_LO = VEC_W'(16);

  // Rank: smaller is more urgent. NMI sits below every programmable level.
  localparam logic [RANK_W-1:0] RANK_NMI    = RANK_W'(0);
  localparam logic [RANK_W-1:0] RANK_THREAD = RANK_W'((1 << PRIO_W) + 1);

  typedef struct packed {
    logic              valid;
    logic [RANK_W-1:0] rank;
    logic [VEC_W-1:0]  num;
  } cand_t;

  localparam cand_t CAND_NONE = '{valid: 1'b0, rank: RANK_THREAD, num: NUM_THREAD};

  function automatic logic [RANK_W-1:0] prio_to_rank(input logic [PRIO_W-1:0] p);
    return RANK_W'(p) + RANK_W'(1);
  endfunction

  // Candidate c displaces the current holder only on strictly better rank.
  function automatic logic displaces(input cand_t c, input cand_t cur);
    return c.valid && (!cur.valid || (c.rank < cur.rank));
  endfunction

  function automatic logic outranks(input logic [RANK_W-1:0] a,
                                    input logic [RANK_W-1:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/sxr_active_rank.sv
module sxr_active_rank
  import sxr_pkg::*;
(
  input  logic [VEC_W-1:0]  active_num,
  input  logic [PRIO_W-1:0] svc_prio,
  input  logic [PRIO_W-1:0] psv_prio,
  input  logic [PRIO_W-1:0] tick_prio,
  input  logic [PRIO_W-1:0] act_ext_prio,
  output logic [RANK_W-1:0] act_rank
);
  logic is_thread;
  logic is_ext;
  logic is_svc;
  logic is_psv;
  logic is_tick;

  assign is_thread = (active_num == NUM_THREAD);
  assign is_ext    = (active_num >= NUM_EXT_LO);
  assign is_svc    = (active_num == NUM_SVC);
  assign is_psv    = (active_num == NUM_PSV);
  assign is_tick   = (active_num == NUM_TICK);

  always_comb begin
    if (is_thread)    act_rank = RANK_THREAD;
    else if (is_ext)  act_rank = prio_to_rank(act_ext_prio);
    else if (is_svc)  act_rank = prio_to_rank(svc_prio);
    else if (is_psv)  act_rank = prio_to_rank(psv_prio);
    else if (is_tick) act_rank = prio_to_rank(tick_prio);
    else              act_rank = RANK_NMI;
  end
endmodule

// File: rtl/sxr_cand_build.sv
module sxr_cand_build
  import sxr_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1,
  localparam int NCAND  = 5
) (
  input  logic                   nmi_pend,
  input  logic                   svc_pend,
  input  logic                   svc_en,
  input  logic [PRIO_W-1:0]      svc_prio,
  input  logic                   psv_pend,
  input  logic                   psv_en,
  input  logic [PRIO_W-1:0]      psv_prio,
  input  logic                   tick_pend,
  input  logic                   tick_en,
  input  logic [PRIO_W-1:0]      tick_prio,
  input  logic                   ext_pend,
  input  logic                   ext_en,
  input  logic [VEC_W-1:0]       ext_num,
  input  logic [PRIO_W-1:0]      ext_prio,
  output cand_t [NCAND-1:0]      cands,
  output logic                   ext_qual
);
  // Slots are ordered by ascending exception number; the picker relies on it.
  assign cands[0] = '{valid: nmi_pend,            rank: RANK_NMI,               num: NUM_NMI};
  assign cands[1] = '{valid: svc_pend && svc_en,  rank: prio_to_rank(svc_prio),  num: NUM_SVC};
  assign cands[2] = '{valid: psv_pend && psv_en,  rank: prio_to_rank(psv_prio),  num: NUM_PSV};
  assign cands[3] = '{valid: tick_pend && tick_en, rank: prio_to_rank(tick_prio), num: NUM_TICK};

  generate
    if (HAS_EXT) begin : g_ext
      assign ext_qual = ext_pend && ext_en;
      assign cands[4] = '{valid: ext_qual, rank: prio_to_rank(ext_prio), num: ext_num};
    end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ^{ext_pend, ext_en, ext_num, ext_prio};
      assign ext_qual   = 1'b0;
      assign cands[4]   = CAND_NONE;
    end
  endgenerate
endmodule

// File: rtl/sxr_pick.sv
module sxr_pick
  import sxr_pkg::*;
#(
  parameter int NCAND = 5
) (
  input  cand_t [NCAND-1:0] cands,
  output cand_t             winner
);
  cand_t stage [NCAND+1];

  assign stage[0] = CAND_NONE;

  generate
    for (genvar i = 0; i < NCAND; i++) begin : g_stage
      // Strict comparison keeps the earlier (lower-numbered) slot on a tie.
      assign stage[i+1] = displaces(cands[i], stage[i]) ? cands[i] : stage[i];
    end
  endgenerate

  assign winner = stage[NCAND];
endmodule

// File: rtl/sysexc_resolver.sv
module sysexc_resolver
  import sxr_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pend,
  input  logic              svc_pend,
  input  logic              svc_en,
  input  logic [PRIO_W-1:0] svc_prio,
  input  logic              psv_pend,
  input  logic              psv_en,
  input  logic [PRIO_W-1:0] psv_prio,
  input  logic              tick_pend,
  input  logic              tick_en,
  input  logic [PRIO_W-1:0] tick_prio,
  input  logic              ext_pend,
  input  logic              ext_en,
  input  logic [VEC_W-1:0]  ext_num,
  input  logic [PRIO_W-1:0] ext_prio,
  input  logic [VEC_W-1:0]  active_num,
  input  logic [PRIO_W-1:0] act_ext_prio,
  output logic [VEC_W-1:0]  pend_vec,
  output logic              ext_pending,
  output logic              preempt_req
);
  localparam int NCAND = 5;

  cand_t [NCAND-1:0] cands;
  cand_t             winner;
  logic              ext_qual;
  logic              win_valid;
  logic [RANK_W-1:0] win_rank;
  logic [RANK_W-1:0] act_rank;
  logic              preempt_next;
  logic [VEC_W-1:0]  vec_next;

  sxr_cand_build #(.HAS_EXT(HAS_EXT)) u_build (
    .nmi_pend  (nmi_pend),
    .svc_pend  (svc_pend),
    .svc_en    (svc_en),
    .svc_prio  (svc_prio),
    .psv_pend  (psv_pend),
    .psv_en    (psv_en),
    .psv_prio  (psv_prio),
    .tick_pend (tick_pend),
    .tick_en   (tick_en),
    .tick_prio (tick_prio),
    .ext_pend  (ext_pend),
    .ext_en    (ext_en),
    .ext_num   (ext_num),
    .ext_prio  (ext_prio),
    .cands     (cands),
    .ext_qual  (ext_qual)
  );

  sxr_pick #(.NCAND(NCAND)) u_pick (
    .cands  (cands),
    .winner (winner)
  );

  sxr_active_rank u_act (
    .active_num   (active_num),
    .svc_prio     (svc_prio),
    .psv_prio     (psv_prio),
    .tick_prio    (tick_prio),
    .act_ext_prio (act_ext_prio),
    .act_rank     (act_rank)
  );

  assign win_valid    = winner.valid;
  assign win_rank     = winner.rank;
  assign vec_next     = win_valid ? winner.num : NUM_THREAD;
  assign preempt_next = win_valid && outranks(win_rank, act_rank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vec    <= NUM_THREAD;
      ext_pending <= 1'b0;
      preempt_req <= 1'b0;
    end else begin
      pend_vec    <= vec_next;
      ext_pending <= ext_qual;
      preempt_req <= preempt_next;
    end
  end
endmodule

// File: rtl/sxr_checker.sv
module sxr_checker
  import sxr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_pend,
  input logic              svc_pend,
  input logic              svc_en,
  input logic              psv_pend,
  input logic              psv_en,
  input logic              tick_pend,
  input logic              tick_en,
  input logic              ext_pend,
  input logic              ext_en,
  input logic [VEC_W-1:0]  active_num,
  input logic [VEC_W-1:0]  pend_vec,
  input logic              ext_pending,
  input logic              preempt_req,
  input logic              win_valid
);
  logic any_qual;
  assign any_qual = nmi_pend || (svc_pend && svc_en) || (psv_pend && psv_en) ||
                    (tick_pend && tick_en) || (ext_pend && ext_en);

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |=> (pend_vec == NUM_NMI)); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !any_qual |=> (pend_vec == NUM_THREAD)); // R6

  AST_EXT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_pend && ext_en) |=> ext_pending); // R7

  AST_EXT_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_pend && ext_en) |=> !ext_pending); // R7

  AST_PREEMPT_HAS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> (pend_vec != NUM_THREAD)); // R8

  AST_THREAD_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((active_num == NUM_THREAD) && win_valid) |=> preempt_req); // R8

  AST_NMI_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_num == NUM_NMI) |=> !preempt_req); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (pend_vec == NUM_THREAD && !ext_pending && !preempt_req)); // R1
endmodule

bind sysexc_resolver sxr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nmi_pend    (nmi_pend),
  .svc_pend    (svc_pend),
  .svc_en      (svc_en),
  .psv_pend    (psv_pend),
  .psv_en      (psv_en),
  .tick_pend   (tick_pend),
  .tick_en     (tick_en),
  .ext_pend    (ext_pend),
  .ext_en      (ext_en),
  .active_num  (active_num),
  .pend_vec    (pend_vec),
  .ext_pending (ext_pending),
  .preempt_req (preempt_req),
  .win_valid   (win_valid)
);

// File: tb/sysexc_resolver_test.sv
`timescale 1ns/1ps
module sysexc_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi_pend = 0, svc_pend = 0, svc_en = 0, psv_pend = 0, psv_en = 0;
  logic       tick_pend = 0, tick_en = 0, ext_pend = 0, ext_en = 0;
  logic [1:0] svc_prio = 0, psv_prio = 0, tick_prio = 0, ext_prio = 0, act_ext_prio = 0;
  logic [8:0] ext_num = 9'd16, active_num = 9'd0;
  logic [8:0] pend_vec;
  logic       ext_pending, preempt_req;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysexc_resolver uut (.*);

  task automatic chk(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Urgency level as the requirements define it: 0 NMI, 1..4 programmable, 5 thread.
  function automatic int lvl(input logic [1:0] p);
    return int'(p) + 1;
  endfunction

  function automatic int act_lvl();
    if (active_num == 0) return 5;
    if (active_num >= 16) return lvl(act_ext_prio);
    case (active_num)
      9'd11: return lvl(svc_prio);
      9'd14: return lvl(psv_prio);
      9'd15: return lvl(tick_prio);
      default: return 0;
    endcase
  endfunction

  // Scan urgency levels from most urgent; at the first populated level take the lowest number.
  task automatic model(output int vec, output int pre, output int ext);
    int nums[5]; int lv[5]; bit ok[5];
    nums = '{2, 11, 14, 15, int'(ext_num)};
    lv   = '{0, lvl(svc_prio), lvl(psv_prio), lvl(tick_prio), lvl(ext_prio)};
    ok   = '{nmi_pend, svc_pend & svc_en, psv_pend & psv_en, tick_pend & tick_en, ext_pend & ext_en};
    vec = 0; pre = 0;
    for (int l = 0; l <= 4 && vec == 0; l++) begin
      int best = 1000;
      for (int k = 0; k < 5; k++)
        if (ok[k] && lv[k] == l && nums[k] < best) best = nums[k];
      if (best != 1000) begin
        vec = best;
        pre = (l < act_lvl()) ? 1 : 0;
      end
    end
    ext = ext_pend & ext_en;
  endtask

  task automatic clear_in();
    {nmi_pend, svc_pend, svc_en, psv_pend, psv_en, tick_pend, tick_en, ext_pend, ext_en} = '0;
    {svc_prio, psv_prio, tick_prio, ext_prio, act_ext_prio} = '0;
    ext_num = 9'd16; active_num = 9'd0;
  endtask

  // Inputs were set at a falling edge; step past the next rising edge and sample.
  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    nmi_pend = 1; ext_pend = 1; ext_en = 1;
    settle();
    chk("R1 vec", pend_vec, 0);
    chk("R1 ext", ext_pending, 0);
    chk("R1 pre", preempt_req, 0);
    @(negedge clk); clear_in(); rst_n = 1;
    settle();
    chk("R6 idle vec", pend_vec, 0);
  endtask

  task automatic t_nmi();
    @(negedge clk);
    clear_in();
    nmi_pend = 1; svc_pend = 1; svc_en = 1; ext_pend = 1; ext_en = 1; ext_num = 9'd40;
    settle();
    chk("R3 nmi over all", pend_vec, 2);
    chk("R8 nmi preempts thread", preempt_req, 1);
  endtask

  task automatic t_order();
    @(negedge clk);
    clear_in();
    svc_pend = 1; svc_en = 1; svc_prio = 2;
    psv_pend = 1; psv_en = 1; psv_prio = 1;
    tick_pend = 1; tick_en = 1; tick_prio = 3;
    settle();
    chk("R4 R2 lower value wins", pend_vec, 14);
    @(negedge clk);
    ext_pend = 1; ext_en = 1; ext_prio = 0; ext_num = 9'd33;
    settle();
    chk("R4 external wins", pend_vec, 33);
    chk("R7 ext flag", ext_pending, 1);
  endtask

  task automatic t_tie();
    @(negedge clk);
    clear_in();
    svc_pend = 1; svc_en = 1; svc_prio = 1;
    psv_pend = 1; psv_en = 1; psv_prio = 1;
    tick_pend = 1; tick_en = 1; tick_prio = 1;
    settle();
    chk("R5 tie lowest number", pend_vec, 11);
    @(negedge clk);
    svc_prio = 2; psv_prio = 0; tick_prio = 0;
    settle();
    chk("R5 tie 14 vs 15", pend_vec, 14);
    @(negedge clk);
    psv_en = 0; ext_pend = 1; ext_en = 1; ext_prio = 0; ext_num = 9'd16;
    settle();
    chk("R5 tick beats ext on tie", pend_vec, 15);
  endtask

  task automatic t_enable();
    @(negedge clk);
    clear_in();
    svc_pend = 1; svc_prio = 0;
    tick_pend = 1; tick_en = 1; tick_prio = 3;
    ext_pend = 1; ext_prio = 0; ext_num = 9'd50;
    settle();
    chk("R6 disabled requests ignored", pend_vec, 15);
    chk("R7 masked ext flag", ext_pending, 0);
    @(negedge clk);
    tick_en = 0;
    settle();
    chk("R6 nothing qualified", pend_vec, 0);
    chk("R8 no winner no preempt", preempt_req, 0);
  endtask

  task automatic t_extflag();
    @(negedge clk);
    clear_in();
    svc_pend = 1; svc_en = 1; svc_prio = 0;
    ext_pend = 1; ext_en = 1; ext_prio = 3; ext_num = 9'd20;
    settle();
    chk("R7 losing ext vec", pend_vec, 11);
    chk("R7 losing ext flag", ext_pending, 1);
  endtask

  task automatic t_preempt();
    @(negedge clk);
    clear_in();
    tick_pend = 1; tick_en = 1; tick_prio = 1;
    active_num = 9'd11; svc_prio = 1;
    settle();
    chk("R8 equal no preempt", preempt_req, 0);
    @(negedge clk); tick_prio = 0;
    settle();
    chk("R8 strictly higher preempts", preempt_req, 1);
    @(negedge clk); active_num = 9'd2;
    settle();
    chk("R9 nmi active held", preempt_req, 0);
    @(negedge clk); active_num = 9'd20; act_ext_prio = 2; tick_prio = 1;
    settle();
    chk("R9 ext active rank", preempt_req, 1);
    @(negedge clk); active_num = 9'd5;
    settle();
    chk("R9 unassigned number top level", preempt_req, 0);
    @(negedge clk); active_num = 9'd15; tick_prio = 2; svc_pend = 1; svc_en = 1; svc_prio = 2;
    settle();
    chk("R9 tick active equal", preempt_req, 0);
    chk("R5 vec under tie", pend_vec, 11);
  endtask

  task automatic t_latency();
    @(negedge clk);
    clear_in();
    settle();
    @(negedge clk);
    psv_pend = 1; psv_en = 1;
    #1;
    chk("R10 no change before edge", pend_vec, 0);
    settle();
    chk("R10 change after edge", pend_vec, 14);
  endtask

  task automatic t_random();
    int ev, ep, ex;
    int acts[8];
    acts = '{0, 2, 11, 14, 15, 7, 16, 200};
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      {nmi_pend, svc_pend, svc_en, psv_pend, psv_en} = 5'($urandom);
      {tick_pend, tick_en, ext_pend, ext_en} = 4'($urandom);
      if (($urandom % 4) != 0) nmi_pend = 0;
      {svc_prio, psv_prio, tick_prio, ext_prio, act_ext_prio} = 10'($urandom);
      ext_num = 9'(16 + ($urandom % 400));
      active_num = 9'(acts[$urandom % 8]);
      model(ev, ep, ex);
      settle();
      chk("R4 random vec", pend_vec, ev);
      chk("R8 random preempt", preempt_req, ep);
      chk("R7 random ext", ext_pending, ex);
    end
  endtask

  initial begin
    t_reset();
    t_nmi();
    t_order();
    t_tie();
    t_enable();
    t_extflag();
    t_preempt();
    t_latency();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule